// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers and status registers of a processor core that runs in several privilege modes. A 4-bit logical register number is translated into a physical storage slot. The translation depends on the operating mode held in the low five bits of the current status word. Registers 0 to 7 and the program counter have one copy that every mode shares. Registers 8 to 12 have a second copy that only the fast-interrupt mode uses. The stack pointer and link register have a separate copy for each of the five exception modes.

The core reads two registers per cycle through combinational ports and writes one register per cycle. It can change the mode field, load the whole status word, and read or write the saved status copy of the mode currently in effect. Every write uses the bank mapping of the mode in effect at the start of that cycle, so a mode change first applies to accesses in the next cycle. The block also registers the incoming interrupt request line.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register in every bank reads zero, the status word is zero, the saved-status read port gives zero, the error flag is low and the registered interrupt line is low.
- R2: Logical registers 0 to 7 and 15 are the same storage in every mode. A value written in one mode reads back unchanged in any other mode.
- R3: Logical registers 8 to 12 use a private copy while the mode field is 0x11 (fast interrupt). In every other mode they use one shared copy.
- R4: Logical registers 13 and 14 have a separate copy for each of the mode fields 0x11, 0x12, 0x13, 0x17 and 0x1B. Every other mode field value, including 0x10, 0x1F and the reset value 0x00, uses the shared copy.
- R5: When mode_set_en is high, bits [4:0] of the status word become {1'b1, mode_sel} at the next edge and the other bits keep their value. If cpsr_wr_en is high in the same cycle, the new mode field overrides the low five bits of the loaded word.
- R6: A register write goes to the physical copy chosen by the mode in effect during that cycle, even when the same cycle also changes the mode.
- R7: Reads are combinational. Reading the register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R8: Each exception mode (0x11, 0x12, 0x13, 0x17, 0x1B) has its own saved status word. spsr_rd_data shows the copy of the current mode, and spsr_wr_en writes only that copy.
- R9: In any other mode, spsr_rd_data reads zero. A saved-status write then changes no saved copy, and spsr_err is high for exactly the following cycle.
- R10: irq_seen equals the value irq_req had in the previous cycle.
- R11: When cpsr_wr_en is high, the whole status word takes cpsr_wr_data at the next edge. The new mode field chooses the banks from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| mode_set_en | input | 1 | Load mode field |
| mode_sel | input | 4 | Low four bits of new mode field |
| cpsr_wr_en | input | 1 | Load whole status word |
| cpsr_wr_data | input | 32 | New status word |
| cpsr_q | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Write saved status of current mode |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_rd_data | output | 32 | Saved status of current mode, or zero |
| spsr_err | output | 1 | Saved-status write attempted with no copy |
| irq_req | input | 1 | Interrupt request line |
| irq_seen | output | 1 | Registered interrupt line |

## Verification
The hardest case is a cycle that writes a banked register and changes the mode at the same time. The write must land in the bank of the outgoing mode, and only a later read in each of the two modes shows where it went. The stimulus sets up this cycle directly, then reads the register back in both modes. A long random phase follows that mixes mode changes, whole-word status loads with odd mode fields, and same-index read/write pairs. Every cycle is compared with a reference model that keeps each bank as its own variables.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5
   } bank_e;

   localparam int LOG_N   = 16;
   localparam int SHARED_N = 9;           // r0..r7 and pc
   localparam int HI_N    = 5;            // r8..r12
   localparam int BANKS   = 6;
   localparam int PHYS_N  = SHARED_N + 2 * HI_N + 2 * BANKS;
   localparam int PIDX_W  = $clog2(PHYS_N);
   localparam int SAVED_N = BANKS - 1;
   localparam int MODE_W  = 5;

   function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
      case (m)
         5'h11:   return BK_FIQ;
         5'h12:   return BK_IRQ;
         5'h13:   return BK_SVC;
         5'h17:   return BK_ABT;
         5'h1B:   return BK_UND;
         default: return BK_USR;
      endcase
   endfunction

   // slot layout: 0..7 low regs, 8 pc, 9..13 shared hi, 14..18 fast hi,
   // 19+2*bank stack pointer, 20+2*bank link
   function automatic logic [PIDX_W-1:0] phys_of(input logic [3:0] li, input bank_e b);
      if (li[3] == 1'b0)
         return {1'b0, li};
      else if (li == 4'd15)
         return 5'd8;
      else if (li <= 4'd12)
         return ((b == BK_FIQ) ? 5'd14 : 5'd9) + {2'b00, li[2:0]};
      else
         return 5'd19 + {1'b0, b, 1'b0} + {4'b0000, li[1]};
   endfunction
endpackage

// File: rtl/bregs_mode_decode.sv
module bregs_mode_decode
   import bregs_pkg::*;
(
   input  logic [MODE_W-1:0] mode_field,
   output bank_e             bank,
   output logic              has_saved,
   output logic [2:0]        saved_slot
);
   always_comb begin
      bank       = bank_of(mode_field);
      has_saved  = (bank != BK_USR);
      saved_slot = has_saved ? (3'(bank) - 3'd1) : 3'd0;
   end
endmodule

// File: rtl/bregs_storage.sv
module bregs_storage
   import bregs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int N      = PHYS_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIDX_W-1:0] rd_a_pidx,
   input  logic [PIDX_W-1:0] rd_b_pidx,
   output logic [DATA_W-1:0] rd_a_data,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [PIDX_W-1:0] wr_pidx,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] slot [N];

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic [DATA_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (wr_en && (wr_pidx == PIDX_W'(i)))
            ent_q <= wr_data;
      end
      assign slot[i] = ent_q;
   end

   assign rd_a_data = (int'(rd_a_pidx) < N) ? slot[rd_a_pidx] : '0;
   assign rd_b_data = (int'(rd_b_pidx) < N) ? slot[rd_b_pidx] : '0;
endmodule

// File: rtl/bregs_status.sv
module bregs_status
   import bregs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_set_en,
   input  logic [3:0]        mode_sel,
   input  logic              cpsr_wr_en,
   input  logic [DATA_W-1:0] cpsr_wr_data,
   output logic [DATA_W-1:0] cpsr_q,
   input  logic              has_saved,
   input  logic [2:0]        saved_slot,
   input  logic              spsr_wr_en,
   input  logic [DATA_W-1:0] spsr_wr_data,
   output logic [DATA_W-1:0] spsr_rd_data,
   output logic              spsr_err
);
   logic [DATA_W-1:0] cpsr_nxt;
   logic [DATA_W-1:0] saved [SAVED_N];

   always_comb begin
      cpsr_nxt = cpsr_wr_en ? cpsr_wr_data : cpsr_q;
      if (mode_set_en)
         cpsr_nxt[MODE_W-1:0] = {1'b1, mode_sel};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpsr_q   <= '0;
         spsr_err <= 1'b0;
      end else begin
         cpsr_q   <= cpsr_nxt;
         spsr_err <= spsr_wr_en && !has_saved;
      end
   end

   for (genvar s = 0; s < SAVED_N; s++) begin : g_saved
      logic [DATA_W-1:0] sv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sv_q <= '0;
         else if (spsr_wr_en && has_saved && (saved_slot == 3'(s)))
            sv_q <= spsr_wr_data;
      end
      assign saved[s] = sv_q;
   end

   assign spsr_rd_data = (has_saved && (int'(saved_slot) < SAVED_N)) ? saved[saved_slot] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bregs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mode_set_en,
   input  logic [3:0]        mode_sel,
   input  logic              cpsr_wr_en,
   input  logic [DATA_W-1:0] cpsr_wr_data,
   output logic [DATA_W-1:0] cpsr_q,
   input  logic              spsr_wr_en,
   input  logic [DATA_W-1:0] spsr_wr_data,
   output logic [DATA_W-1:0] spsr_rd_data,
   output logic              spsr_err,
   input  logic              irq_req,
   output logic              irq_seen
);
   if (DATA_W < 8) begin : g_chk_width
      $error("banked_regfile: DATA_W must hold the mode field");
   end
   if (PHYS_N > (1 << PIDX_W)) begin : g_chk_pidx
      $error("banked_regfile: slot index too narrow");
   end

   bank_e             cur_bank;
   logic              cur_has_saved;
   logic [2:0]        cur_saved_slot;
   logic [PIDX_W-1:0] pa, pb, pw;

   bregs_mode_decode u_dec (
      .mode_field (cpsr_q[MODE_W-1:0]),
      .bank       (cur_bank),
      .has_saved  (cur_has_saved),
      .saved_slot (cur_saved_slot)
   );

   always_comb begin
      pa = phys_of(rd_a_idx, cur_bank);
      pb = phys_of(rd_b_idx, cur_bank);
      pw = phys_of(wr_idx, cur_bank);
   end

   bregs_storage #(.DATA_W(DATA_W), .N(PHYS_N)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_a_pidx (pa),
      .rd_b_pidx (pb),
      .rd_a_data (rd_a_data),
      .rd_b_data (rd_b_data),
      .wr_en     (wr_en),
      .wr_pidx   (pw),
      .wr_data   (wr_data)
   );

   bregs_status #(.DATA_W(DATA_W)) u_stat (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_set_en  (mode_set_en),
      .mode_sel     (mode_sel),
      .cpsr_wr_en   (cpsr_wr_en),
      .cpsr_wr_data (cpsr_wr_data),
      .cpsr_q       (cpsr_q),
      .has_saved    (cur_has_saved),
      .saved_slot   (cur_saved_slot),
      .spsr_wr_en   (spsr_wr_en),
      .spsr_wr_data (spsr_wr_data),
      .spsr_rd_data (spsr_rd_data),
      .spsr_err     (spsr_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_seen <= 1'b0;
      else
         irq_seen <= irq_req;
   end
endmodule

// File: rtl/bregs_chk.sv
module bregs_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              mode_set_en,
   input logic [3:0]        mode_sel,
   input logic [DATA_W-1:0] cpsr_q,
   input logic              spsr_wr_en,
   input logic [DATA_W-1:0] spsr_rd_data,
   input logic              spsr_err,
   input logic              has_saved,
   input logic              irq_req,
   input logic              irq_seen
);
   // R5
   mode_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_set_en |=> (cpsr_q[4:0] == {1'b1, $past(mode_sel)}));

   // R9
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_err |-> ($past(spsr_wr_en) && !$past(has_saved)));

   // R9
   no_saved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !has_saved |-> (spsr_rd_data == '0));

   // R10
   irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_seen == $past(irq_req));

   // R7
   write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && (rd_a_idx == $past(wr_idx)) && (cpsr_q[4:0] == $past(cpsr_q[4:0])))
      |-> (rd_a_data == $past(wr_data)));
endmodule

bind banked_regfile bregs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_a_idx     (rd_a_idx),
   .rd_a_data    (rd_a_data),
   .wr_en        (wr_en),
   .wr_idx       (wr_idx),
   .wr_data      (wr_data),
   .mode_set_en  (mode_set_en),
   .mode_sel     (mode_sel),
   .cpsr_q       (cpsr_q),
   .spsr_wr_en   (spsr_wr_en),
   .spsr_rd_data (spsr_rd_data),
   .spsr_err     (spsr_err),
   .has_saved    (cur_has_saved),
   .irq_req      (irq_req),
   .irq_seen     (irq_seen)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, mode_sel = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0, cpsr_wr_data = '0;
   logic [31:0] cpsr_q, spsr_wr_data = '0, spsr_rd_data;
   logic        wr_en = 0, mode_set_en = 0, cpsr_wr_en = 0, spsr_wr_en = 0;
   logic        spsr_err, irq_req = 0, irq_seen;

   int total = 0, bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   banked_regfile dut (.*);

   // reference model: each bank kept as separate variables
   logic [31:0] m_com [0:15];
   logic [31:0] m_fhi [8:12];
   logic [31:0] m_sp [1:5], m_lr [1:5], m_sv [1:5];
   logic [31:0] m_cpsr;
   logic        m_err, m_irq;

   function automatic int bk(input logic [4:0] m);
      case (m)
         5'h11: return 1;
         5'h12: return 2;
         5'h13: return 3;
         5'h17: return 4;
         5'h1B: return 5;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] mread(input int i, input int b);
      if (i >= 8 && i <= 12 && b == 1) return m_fhi[i];
      if (i == 13 && b != 0) return m_sp[b];
      if (i == 14 && b != 0) return m_lr[b];
      return m_com[i];
   endfunction

   task automatic mwrite(input int i, input int b, input logic [31:0] d);
      if (i >= 8 && i <= 12 && b == 1) m_fhi[i] = d;
      else if (i == 13 && b != 0) m_sp[b] = d;
      else if (i == 14 && b != 0) m_lr[b] = d;
      else m_com[i] = d;
   endtask

   function automatic string rtag(input int i);
      if (i < 8 || i == 15) return "R2";
      if (i <= 12) return "R3";
      return "R4";
   endfunction

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", t, act, exp);
      end
   endtask

   // one clock: compare at the falling edge, update the model after the rising edge
   task automatic tick(input string t = "");
      int b;
      @(negedge clk);
      b = bk(m_cpsr[4:0]);
      chk(t != "" ? t : rtag(int'(rd_a_idx)), rd_a_data, mread(int'(rd_a_idx), b));
      chk(t != "" ? t : rtag(int'(rd_b_idx)), rd_b_data, mread(int'(rd_b_idx), b));
      chk(t != "" ? t : "R5", cpsr_q, m_cpsr);
      chk(t != "" ? t : "R8", spsr_rd_data, (b != 0) ? m_sv[b] : 32'h0);
      chk(t != "" ? t : "R9", {31'h0, spsr_err}, {31'h0, m_err});
      chk(t != "" ? t : "R10", {31'h0, irq_seen}, {31'h0, m_irq});
      @(posedge clk);
      if (wr_en) mwrite(int'(wr_idx), b, wr_data);
      if (spsr_wr_en && b != 0) m_sv[b] = spsr_wr_data;
      m_err = spsr_wr_en && (b == 0);
      if (cpsr_wr_en) m_cpsr = cpsr_wr_data;
      if (mode_set_en) m_cpsr[4:0] = {1'b1, mode_sel};
      m_irq = irq_req;
      #1;
      wr_en = 0; spsr_wr_en = 0; mode_set_en = 0; cpsr_wr_en = 0;
   endtask

   task automatic set_mode(input logic [3:0] s, input string t);
      mode_set_en = 1; mode_sel = s;
      tick(t);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] codes [7];
      codes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h7, 4'hB, 4'hF};
      for (int i = 0; i < 16; i++) m_com[i] = '0;
      for (int i = 8; i <= 12; i++) m_fhi[i] = '0;
      for (int i = 1; i <= 5; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_sv[i] = '0; end
      m_cpsr = '0; m_err = 0; m_irq = 0;

      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      rd_a_idx = 13; rd_b_idx = 9;
      tick("R1");

      // R7: same-cycle read of the written register gives old value
      wr_en = 1; wr_idx = 3; wr_data = 32'hA5A5_0003; rd_a_idx = 3;
      tick("R7");
      tick("R7");

      // R6: write r10 in the cycle that switches to fast interrupt
      wr_en = 1; wr_idx = 10; wr_data = 32'h1111_000A;
      set_mode(4'h1, "R6");
      rd_a_idx = 10; rd_b_idx = 13;
      tick("R6");
      wr_en = 1; wr_idx = 10; wr_data = 32'h2222_000A;
      tick("R3");
      set_mode(4'h0, "R3");
      tick("R3");

      // R4: stack pointer per mode
      for (int k = 0; k < 7; k++) begin
         set_mode(codes[k], "R4");
         wr_en = 1; wr_idx = 13; wr_data = 32'h5000_0000 + k;
         tick("R4");
      end
      for (int k = 0; k < 7; k++) begin
         rd_a_idx = 13; rd_b_idx = 14;
         set_mode(codes[k], "R4");
         tick("R4");
      end

      // R2: shared registers across modes
      set_mode(4'h1, "R2");
      wr_en = 1; wr_idx = 15; wr_data = 32'h0000_8000; tick("R2");
      set_mode(4'hB, "R2");
      rd_a_idx = 15; rd_b_idx = 3; tick("R2");

      // R8 / R9: saved status access
      set_mode(4'h0, "R9");
      spsr_wr_en = 1; spsr_wr_data = 32'hDEAD_0001; tick("R9");
      tick("R9");
      set_mode(4'h3, "R8");
      spsr_wr_en = 1; spsr_wr_data = 32'h0000_00D3; tick("R8");
      set_mode(4'h2, "R8");
      spsr_wr_en = 1; spsr_wr_data = 32'h0000_00D2; tick("R8");
      set_mode(4'h3, "R8");
      tick("R8");
      set_mode(4'hF, "R9");
      spsr_wr_en = 1; spsr_wr_data = 32'hBAD0_0000; tick("R9");
      tick("R9");

      // R11 / R5: whole-word load, then combined with mode set
      cpsr_wr_en = 1; cpsr_wr_data = 32'hF000_00D7; tick("R11");
      rd_a_idx = 13; tick("R11");
      cpsr_wr_en = 1; cpsr_wr_data = 32'h0F00_0005; mode_set_en = 1; mode_sel = 4'h2;
      tick("R5");
      tick("R5");

      // R10: interrupt line
      irq_req = 1; tick("R10");
      irq_req = 0; tick("R10");
      tick("R10");

      // random phase
      for (int n = 0; n < 1500; n++) begin
         rd_a_idx = 4'($urandom_range(0, 15));
         rd_b_idx = 4'($urandom_range(0, 15));
         wr_en = ($urandom_range(0, 3) != 0);
         wr_idx = ($urandom_range(0, 3) == 0) ? rd_a_idx : 4'($urandom_range(0, 15));
         wr_data = $urandom;
         mode_set_en = ($urandom_range(0, 4) == 0);
         mode_sel = codes[$urandom_range(0, 6)];
         cpsr_wr_en = ($urandom_range(0, 19) == 0);
         cpsr_wr_data = $urandom;
         spsr_wr_en = ($urandom_range(0, 3) == 0);
         spsr_wr_data = $urandom;
         irq_req = $urandom_range(0, 1);
         tick();
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule